// File: doc/BRIEF.md
# Receive Mailbox Lock Controller

This block sits between a CPU register port and the receive engine of a CAN-style controller. It owns a bank of receive mailboxes. Each mailbox holds a control/status word carrying a four-bit code field, an identifier word and data words. The receive engine hands over one finished frame at a time, together with the index of the mailbox it matched. The block decides whether the frame is stored, held back or dropped. It keeps the code field of every mailbox up to date, raises per-mailbox flags and drives one interrupt line.

Read coherency rests on a single lock. Reading a mailbox's control/status word locks that mailbox. Reading the free-running timer releases the lock, and reading another mailbox's control/status word moves the lock there. A frame that completes for the locked mailbox waits in a one-entry holding register and is written when the lock goes away. While a frame is being written, the mailbox's code shows a BUSY bit. A serviced mailbox keeps the code FULL and never returns to EMPTY by itself. Software therefore waits on the flag registers, not on the code field. A software write to a control/status word takes the mailbox out of any reception in flight.

Top module: `rxmb_guard`

## Requirements
- R1: After reset every mailbox word reads 0 (code INACTIVE = 0000), the flag and mask registers read 0, `irq` is low and `cpu_rdata` is 0.
- R2: A CPU read of word 0 of mailbox N locks N. A frame that completes for N while N is locked does not change N's words or its flag.
- R3: A CPU read of the timer register (address 0x80) releases the lock. A frame held for the released mailbox is then written within three cycles, and its flag is set.
- R4: A CPU read of word 0 of another mailbox M moves the lock to M. This releases the frame held for N, and frames for M are then held.
- R5: The code field is bits 27:24 of word 0, and bit 24 is BUSY. In the cycle after a frame is accepted, a read of that mailbox's word 0 returns the previous code with bit 24 set.
- R6: A stored frame sets the code to FULL (0010), and the code stays FULL after the mailbox is read and unlocked.
- R7: A frame written into a mailbox whose code is FULL or OVERRUN (0110) sets the code to OVERRUN. So does a frame that replaced an earlier held frame for the same mailbox.
- R8: A CPU write to word 0 of a mailbox drops any frame for that mailbox that is arriving, held or being written in that cycle: no word other than the written one changes and no flag is set.
- R9: Each stored frame sets the mailbox's flag bit. Mailboxes 0 to 15 map to bits 15:0 at address 0x81 and mailboxes 16 to 31 map to bits 15:0 at address 0x82. Writing 1 to a bit clears it and leaves the other bits unchanged.
- R10: A stored frame always writes the received identifier into word 1 and the received control bits, with the code replaced, into word 0.
- R11: While bit 0 of the configuration register (0x85) is 1, frames marked `rx_self` are not stored and set no flag. While it is 0, they are stored like other frames.
- R12: `irq` is high exactly when some flag bit and its mask bit (0x83 low half, 0x84 high half) are both 1.
- R13: `cpu_rdata` changes only on the clock edge that samples `cpu_rd`, and it shows the addressed word in the next cycle. The timer register advances by one every cycle.
- R14: A frame for a mailbox whose code is not EMPTY (0100), FULL or OVERRUN is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 8 | Bit 7 = 0: mailbox {index[6:2], word[1:0]}; bit 7 = 1: register select in bits 2:0 |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Registered read data |
| rx_valid | input | 1 | A finished frame is offered this cycle |
| rx_idx | input | 5 | Index of the matched mailbox |
| rx_self | input | 1 | Frame was sent by this node |
| rx_ctrl | input | 32 | Received control bits (length and others) |
| rx_id | input | 32 | Received identifier |
| rx_payload | input | 64 | Received data words, word 2 in the low half |
| irq | output | 1 | Masked OR of all mailbox flags |

## Verification
Two functions can act on the same cycle. One is a lock change from a CPU read of a status word or the timer. The other is a frame completion that targets the locked mailbox or lands on the cycle a software write forces the code. The bench provokes both cases. It locks a mailbox, delivers frames into it, then releases the lock with a timer read or by moving it to another mailbox. In a separate case it drives `rx_valid` and a status-word write on the very same edge. Each case is judged at the ports, from the identifier word, the code field and the flag register read back afterwards, against the held, committed or dropped outcome the requirements dictate.

// File: rtl/rxmb_pkg.sv
package rxmb_pkg;

   typedef logic [3:0] code_t;

   localparam code_t CODE_INACTIVE = 4'b0000;
   localparam code_t CODE_EMPTY    = 4'b0100;
   localparam code_t CODE_FULL     = 4'b0010;
   localparam code_t CODE_OVERRUN  = 4'b0110;

   typedef enum logic [2:0] {
      RG_TIMER   = 3'd0,
      RG_FLAG_LO = 3'd1,
      RG_FLAG_HI = 3'd2,
      RG_MASK_LO = 3'd3,
      RG_MASK_HI = 3'd4,
      RG_CFG     = 3'd5
   } reg_sel_t;

   // a mailbox takes part in reception only with one of these codes
   function automatic logic code_active(input code_t c);
      return (c == CODE_EMPTY) || (c == CODE_FULL) || (c == CODE_OVERRUN);
   endfunction

endpackage

// File: rtl/rxmb_lock.sv
module rxmb_lock #(
   parameter int IW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic [IW-1:0] take_idx,
   input  logic          drop,
   output logic          lock_valid,
   output logic [IW-1:0] lock_idx
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_valid <= 1'b0;
         lock_idx   <= '0;
      end else if (take) begin
         lock_valid <= 1'b1;
         lock_idx   <= take_idx;
      end else if (drop) begin
         lock_valid <= 1'b0;
      end
   end

endmodule

// File: rtl/rxmb_intake.sv
module rxmb_intake #(
   parameter int IW = 5,
   parameter int DW = 32,
   parameter int PW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [IW-1:0] rx_idx,
   input  logic          rx_self,
   input  logic [DW-1:0] rx_ctrl,
   input  logic [DW-1:0] rx_id,
   input  logic [PW-1:0] rx_payload,
   input  logic          self_rx_off,
   input  logic          tgt_active,
   input  logic          kill_en,
   input  logic [IW-1:0] kill_idx,
   input  logic          lock_valid,
   input  logic [IW-1:0] lock_idx,
   output logic          mv_valid,
   output logic [IW-1:0] mv_idx,
   output logic [DW-1:0] mv_ctrl,
   output logic [DW-1:0] mv_id,
   output logic [PW-1:0] mv_payload,
   output logic          mv_ovr
);

   typedef struct packed {
      logic [IW-1:0] idx;
      logic [DW-1:0] ctrl;
      logic [DW-1:0] id;
      logic [PW-1:0] pay;
   } frame_t;

   frame_t rx_f, pend_q, mv_q;
   logic   pend_v, pend_ovr_q, mv_v, mv_ovr_q;
   logic   accept, hits_lock, direct, to_pend, pend_kill, pend_locked, drain;

   assign rx_f = '{idx: rx_idx, ctrl: rx_ctrl, id: rx_id, pay: rx_payload};

   always_comb begin
      accept      = rx_valid && tgt_active && !(rx_self && self_rx_off)
                    && !(kill_en && (kill_idx == rx_idx));
      hits_lock   = lock_valid && (lock_idx == rx_idx);
      direct      = accept && !hits_lock;
      to_pend     = accept && hits_lock;
      pend_kill   = pend_v && kill_en && (kill_idx == pend_q.idx);
      pend_locked = lock_valid && (lock_idx == pend_q.idx);
      // a direct frame owns the write slot; the held one waits a cycle
      drain       = pend_v && !pend_kill && !pend_locked && !direct;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v     <= 1'b0;
         pend_ovr_q <= 1'b0;
         pend_q     <= '0;
      end else if (to_pend) begin
         pend_v     <= 1'b1;
         pend_ovr_q <= pend_v && !pend_kill && (pend_q.idx == rx_idx);
         pend_q     <= rx_f;
      end else if (drain || pend_kill) begin
         pend_v     <= 1'b0;
         pend_ovr_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mv_v     <= 1'b0;
         mv_ovr_q <= 1'b0;
         mv_q     <= '0;
      end else begin
         mv_v     <= direct || drain;
         mv_ovr_q <= drain && pend_ovr_q;
         if (direct)     mv_q <= rx_f;
         else if (drain) mv_q <= pend_q;
      end
   end

   assign mv_valid   = mv_v;
   assign mv_idx     = mv_q.idx;
   assign mv_ctrl    = mv_q.ctrl;
   assign mv_id      = mv_q.id;
   assign mv_payload = mv_q.pay;
   assign mv_ovr     = mv_ovr_q;

endmodule

// File: rtl/rxmb_store.sv
module rxmb_store
   import rxmb_pkg::*;
#(
   parameter int NUM_MB   = 32,
   parameter int WORDS    = 4,
   parameter int DW       = 32,
   parameter int CODE_LSB = 24,
   parameter int IW       = $clog2(NUM_MB),
   parameter int WW       = $clog2(WORDS),
   parameter int PW       = (WORDS - 2) * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_we,
   input  logic [IW-1:0] cpu_idx,
   input  logic [WW-1:0] cpu_word,
   input  logic [DW-1:0] cpu_wdata,
   input  logic          commit_en,
   input  logic [IW-1:0] commit_idx,
   input  logic [DW-1:0] commit_ctrl,
   input  logic [DW-1:0] commit_id,
   input  logic [PW-1:0] commit_payload,
   input  logic          commit_ovr,
   input  logic [IW-1:0] rd_idx,
   input  logic [WW-1:0] rd_word,
   output logic [DW-1:0] rd_data,
   input  logic [IW-1:0] probe_idx,
   output code_t         probe_code
);

   localparam logic [DW-1:0] CODE_MASK = DW'(4'hF) << CODE_LSB;

   logic [DW-1:0] cells [NUM_MB][WORDS];
   code_t         cur_code, new_code;
   logic [DW-1:0] ctrl_new;

   always_comb begin
      cur_code = cells[commit_idx][0][CODE_LSB +: 4];
      new_code = (commit_ovr || cur_code == CODE_FULL || cur_code == CODE_OVERRUN)
                 ? CODE_OVERRUN : CODE_FULL;
      ctrl_new = (commit_ctrl & ~CODE_MASK) | (DW'(new_code) << CODE_LSB);
   end

   for (genvar gi = 0; gi < NUM_MB; gi++) begin : g_mb
      for (genvar gw = 0; gw < WORDS; gw++) begin : g_word
         logic [DW-1:0] q;
         logic [DW-1:0] fill;
         logic          hit_rx, hit_cpu;

         if (gw == 0) begin : g_ctl
            assign fill = ctrl_new;
         end else if (gw == 1) begin : g_id
            assign fill = commit_id;
         end else begin : g_dat
            assign fill = commit_payload[(gw-2)*DW +: DW];
         end

         assign hit_rx  = commit_en && (commit_idx == IW'(gi));
         assign hit_cpu = cpu_we && (cpu_idx == IW'(gi)) && (cpu_word == WW'(gw));

         always_ff @(posedge clk) begin
            if (!rst_n)       q <= '0;
            else if (hit_rx)  q <= fill;
            else if (hit_cpu) q <= cpu_wdata;
         end

         assign cells[gi][gw] = q;
      end
   end

   assign rd_data    = cells[rd_idx][rd_word];
   assign probe_code = cells[probe_idx][0][CODE_LSB +: 4];

endmodule

// File: rtl/rxmb_flags.sv
module rxmb_flags #(
   parameter int NUM_MB = 32,
   parameter int IW     = $clog2(NUM_MB),
   parameter int HALF   = NUM_MB / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [IW-1:0]     set_idx,
   input  logic [1:0]        clr_we,
   input  logic [1:0]        mask_we,
   input  logic [HALF-1:0]   wdata,
   output logic [NUM_MB-1:0] flags,
   output logic [NUM_MB-1:0] mask,
   output logic              irq
);

   logic [NUM_MB-1:0] set_vec;

   assign set_vec = set_en ? (NUM_MB'(1) << set_idx) : '0;

   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HALF-1:0] f_q, m_q, clr;

      assign clr = clr_we[h] ? wdata : '0;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            f_q <= '0;
            m_q <= '0;
         end else begin
            f_q <= (f_q & ~clr) | set_vec[h*HALF +: HALF];
            if (mask_we[h]) m_q <= wdata;
         end
      end

      assign flags[h*HALF +: HALF] = f_q;
      assign mask[h*HALF +: HALF]  = m_q;
   end

   assign irq = |(flags & mask);

endmodule

// File: rtl/rxmb_guard.sv
module rxmb_guard
   import rxmb_pkg::*;
#(
   parameter int NUM_MB   = 32,
   parameter int WORDS    = 4,
   parameter int DW       = 32,
   parameter int TW       = 16,
   parameter int CODE_LSB = 24,
   localparam int IW      = $clog2(NUM_MB),
   localparam int WW      = $clog2(WORDS),
   localparam int AW      = IW + WW + 1,
   localparam int PW      = (WORDS - 2) * DW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_rd,
   input  logic          cpu_wr,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   output logic [DW-1:0] cpu_rdata,
   input  logic          rx_valid,
   input  logic [IW-1:0] rx_idx,
   input  logic          rx_self,
   input  logic [DW-1:0] rx_ctrl,
   input  logic [DW-1:0] rx_id,
   input  logic [PW-1:0] rx_payload,
   output logic          irq
);

   localparam int HALF = NUM_MB / 2;

   if (NUM_MB < 2 || NUM_MB % 2 != 0 || HALF > DW) begin : g_bad_count
      $error("rxmb_guard: NUM_MB must be even and its half must fit in DW");
   end
   if (WORDS < 3 || (1 << WW) != WORDS) begin : g_bad_words
      $error("rxmb_guard: WORDS must be a power of two of at least 4");
   end
   if (CODE_LSB + 4 > DW || TW > DW || IW + WW < 3) begin : g_bad_width
      $error("rxmb_guard: code field, timer or address width out of range");
   end

   // address decode
   logic          is_reg;
   logic [IW-1:0] a_idx;
   logic [WW-1:0] a_word;
   reg_sel_t      a_sel;
   logic          ctrl_rd, tmr_rd, ctrl_wr, mb_we;

   assign is_reg  = cpu_addr[AW-1];
   assign a_idx   = cpu_addr[AW-2:WW];
   assign a_word  = cpu_addr[WW-1:0];
   assign a_sel   = reg_sel_t'(cpu_addr[2:0]);
   assign ctrl_rd = cpu_rd && !is_reg && (a_word == '0);
   assign tmr_rd  = cpu_rd && is_reg && (a_sel == RG_TIMER);
   assign ctrl_wr = cpu_wr && !is_reg && (a_word == '0);
   assign mb_we   = cpu_wr && !is_reg;

   // lock
   logic          lock_valid;
   logic [IW-1:0] lock_idx;

   rxmb_lock #(.IW(IW)) u_lock (
      .clk        (clk),
      .rst_n      (rst_n),
      .take       (ctrl_rd),
      .take_idx   (a_idx),
      .drop       (tmr_rd),
      .lock_valid (lock_valid),
      .lock_idx   (lock_idx)
   );

   // configuration and timer
   logic          srx_off;
   logic [TW-1:0] tmr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         srx_off <= 1'b0;
         tmr     <= '0;
      end else begin
         tmr <= tmr + 1'b1;
         if (cpu_wr && is_reg && a_sel == RG_CFG) srx_off <= cpu_wdata[0];
      end
   end

   // frame intake
   code_t         rx_code;
   logic          mv_valid, mv_ovr, commit_en;
   logic [IW-1:0] mv_idx;
   logic [DW-1:0] mv_ctrl, mv_id;
   logic [PW-1:0] mv_payload;

   rxmb_intake #(.IW(IW), .DW(DW), .PW(PW)) u_intake (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_valid    (rx_valid),
      .rx_idx      (rx_idx),
      .rx_self     (rx_self),
      .rx_ctrl     (rx_ctrl),
      .rx_id       (rx_id),
      .rx_payload  (rx_payload),
      .self_rx_off (srx_off),
      .tgt_active  (code_active(rx_code)),
      .kill_en     (ctrl_wr),
      .kill_idx    (a_idx),
      .lock_valid  (lock_valid),
      .lock_idx    (lock_idx),
      .mv_valid    (mv_valid),
      .mv_idx      (mv_idx),
      .mv_ctrl     (mv_ctrl),
      .mv_id       (mv_id),
      .mv_payload  (mv_payload),
      .mv_ovr      (mv_ovr)
   );

   // a status-word write in the write cycle cancels the frame
   assign commit_en = mv_valid && !(ctrl_wr && (a_idx == mv_idx));

   // mailbox storage
   logic [DW-1:0] mb_rd;

   rxmb_store #(
      .NUM_MB(NUM_MB), .WORDS(WORDS), .DW(DW), .CODE_LSB(CODE_LSB)
   ) u_store (
      .clk            (clk),
      .rst_n          (rst_n),
      .cpu_we         (mb_we),
      .cpu_idx        (a_idx),
      .cpu_word       (a_word),
      .cpu_wdata      (cpu_wdata),
      .commit_en      (commit_en),
      .commit_idx     (mv_idx),
      .commit_ctrl    (mv_ctrl),
      .commit_id      (mv_id),
      .commit_payload (mv_payload),
      .commit_ovr     (mv_ovr),
      .rd_idx         (a_idx),
      .rd_word        (a_word),
      .rd_data        (mb_rd),
      .probe_idx      (rx_idx),
      .probe_code     (rx_code)
   );

   // flags and interrupt
   logic [NUM_MB-1:0] flags, mask;
   logic [1:0]        clr_we, mask_we;

   assign clr_we  = {cpu_wr && is_reg && a_sel == RG_FLAG_HI,
                     cpu_wr && is_reg && a_sel == RG_FLAG_LO};
   assign mask_we = {cpu_wr && is_reg && a_sel == RG_MASK_HI,
                     cpu_wr && is_reg && a_sel == RG_MASK_LO};

   rxmb_flags #(.NUM_MB(NUM_MB)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (commit_en),
      .set_idx (mv_idx),
      .clr_we  (clr_we),
      .mask_we (mask_we),
      .wdata   (cpu_wdata[HALF-1:0]),
      .flags   (flags),
      .mask    (mask),
      .irq     (irq)
   );

   // registered read path
   logic [DW-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      if (!is_reg) begin
         rd_next = mb_rd;
         if (a_word == '0 && mv_valid && mv_idx == a_idx) rd_next[CODE_LSB] = 1'b1;
      end else begin
         case (a_sel)
            RG_TIMER:   rd_next = DW'(tmr);
            RG_FLAG_LO: rd_next = DW'(flags[HALF-1:0]);
            RG_FLAG_HI: rd_next = DW'(flags[NUM_MB-1:HALF]);
            RG_MASK_LO: rd_next = DW'(mask[HALF-1:0]);
            RG_MASK_HI: rd_next = DW'(mask[NUM_MB-1:HALF]);
            RG_CFG:     rd_next = DW'(srx_off);
            default:    rd_next = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      cpu_rdata <= '0;
      else if (cpu_rd) cpu_rdata <= rd_next;
   end

endmodule

// File: rtl/rxmb_guard_chk.sv
module rxmb_guard_chk #(
   parameter int NUM_MB = 32,
   parameter int WORDS  = 4,
   parameter int DW     = 32,
   localparam int IW    = $clog2(NUM_MB),
   localparam int WW    = $clog2(WORDS),
   localparam int AW    = IW + WW + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_rd,
   input logic [AW-1:0]     cpu_addr,
   input logic [DW-1:0]     cpu_rdata,
   input logic              lock_valid,
   input logic [IW-1:0]     lock_idx,
   input logic              commit_en,
   input logic [IW-1:0]     commit_idx,
   input logic [NUM_MB-1:0] flags,
   input logic [NUM_MB-1:0] mask,
   input logic              irq
);

   logic status_read, timer_read;

   assign status_read = cpu_rd && !cpu_addr[AW-1] && (cpu_addr[WW-1:0] == '0);
   assign timer_read  = cpu_rd && cpu_addr[AW-1] && (cpu_addr[2:0] == 3'd0);

   assert_lock_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
      status_read |=> lock_valid && (lock_idx == $past(cpu_addr[AW-2:WW])));

   assert_lock_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
      timer_read |=> !lock_valid);

   assert_flag_on_store_R9: assert property (@(posedge clk) disable iff (!rst_n)
      commit_en |=> flags[$past(commit_idx)]);

   assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & mask) == '0) |-> !irq);

   assert_irq_raise_R12: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & mask) != '0) |-> irq);

   assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_rd |=> $stable(cpu_rdata));

endmodule

bind rxmb_guard rxmb_guard_chk #(
   .NUM_MB (NUM_MB),
   .WORDS  (WORDS),
   .DW     (DW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_rd     (cpu_rd),
   .cpu_addr   (cpu_addr),
   .cpu_rdata  (cpu_rdata),
   .lock_valid (lock_valid),
   .lock_idx   (lock_idx),
   .commit_en  (commit_en),
   .commit_idx (mv_idx),
   .flags      (flags),
   .mask       (mask),
   .irq        (irq)
);

// File: tb/rxmb_guard_test.sv
module rxmb_guard_test;

   localparam logic [31:0] C_EMPTY = 32'h0400_0000;
   localparam logic [31:0] C_FULL  = 32'h0200_0008;
   localparam logic [31:0] C_OVR   = 32'h0600_0008;
   localparam logic [31:0] C_BUSY  = 32'h0100_0000;
   localparam logic [7:0]  A_TMR = 8'h80, A_FLO = 8'h81, A_FHI = 8'h82,
                           A_MLO = 8'h83, A_CFG = 8'h85;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [7:0]  cpu_addr = '0;
   logic [31:0] cpu_wdata = '0, cpu_rdata;
   logic        rx_valid = 1'b0, rx_self = 1'b0, irq;
   logic [4:0]  rx_idx = '0;
   logic [31:0] rx_ctrl = '0, rx_id = '0;
   logic [63:0] rx_payload = '0;

   int nchk = 0, nerr = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   rxmb_guard uut (.*);

   typedef struct packed {
      logic [4:0]  idx;
      logic        self;
      logic        dis;
      logic [31:0] id;
      logic        stored;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{5'd2,  1'b0, 1'b0, 32'h0000_0111, 1'b1},
      '{5'd20, 1'b0, 1'b0, 32'h0000_0222, 1'b1},
      '{5'd7,  1'b1, 1'b1, 32'h0000_0333, 1'b0},
      '{5'd7,  1'b1, 1'b0, 32'h0000_0444, 1'b1},
      '{5'd31, 1'b0, 1'b1, 32'h0000_0555, 1'b1},
      '{5'd16, 1'b1, 1'b1, 32'h0000_0666, 1'b0}
   };

   function automatic logic [7:0] mba(input int idx, input int w);
      return 8'((idx << 2) | w);
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      nchk++;
      if (got !== exp) begin
         nerr++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk); cpu_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); cpu_rd = 1'b1; cpu_addr = a;
      @(negedge clk); cpu_rd = 1'b0; d = cpu_rdata;
   endtask

   task automatic send(input int idx, input logic self, input logic [31:0] id);
      @(negedge clk);
      rx_valid = 1'b1; rx_idx = 5'(idx); rx_self = self; rx_id = id;
      rx_ctrl = 32'h8; rx_payload = {~id, id};
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic clear_flags();
      wr(A_FLO, 32'hFFFF);
      wr(A_FHI, 32'hFFFF);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         nchk++; nerr++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
         $finish;
      end
   end

   initial begin
      logic [31:0] v, t1, t2;
      idle(3);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 rdata", cpu_rdata, 32'h0);
      check("R1 irq", 32'(irq), 32'h0);
      rd(mba(3, 0), v);  check("R1 code", v, 32'h0);
      rd(A_FLO, v);      check("R1 flags", v, 32'h0);
      rd(A_MLO, v);      check("R1 mask", v, 32'h0);

      // R14 inactive mailbox ignores frames
      send(5, 1'b0, 32'h55);
      idle(2);
      rd(A_FLO, v);      check("R14 flag", v, 32'h0);
      rd(mba(5, 1), v);  check("R14 id", v, 32'h0);

      // table: R9 R10 R11
      foreach (VEC[k]) begin
         vec_t e = VEC[k];
         logic [7:0] fa = (e.idx >= 16) ? A_FHI : A_FLO;
         int bitpos = (e.idx >= 16) ? int'(e.idx) - 16 : int'(e.idx);
         rd(A_TMR, v);
         wr(A_CFG, 32'(e.dis));
         wr(mba(e.idx, 1), 32'hABC);
         wr(mba(e.idx, 0), C_EMPTY);
         clear_flags();
         send(e.idx, e.self, e.id);
         idle(2);
         rd(fa, v);
         check("R9 R11 flag bit", 32'(v[bitpos]), 32'(e.stored));
         rd(mba(e.idx, 1), v);
         check("R10 R11 id word", v, e.stored ? e.id : 32'hABC);
         rd(mba(e.idx, 2), v);
         check("R10 data word", v, e.stored ? e.id : 32'h0);
         rd(mba(e.idx, 0), v);
         check("R6 R11 code", v, e.stored ? C_FULL : C_EMPTY);
      end
      wr(A_CFG, 32'h0);
      rd(A_TMR, v);

      // R12 and R9 write-one-to-clear
      clear_flags();
      wr(mba(3, 0), C_EMPTY);
      wr(mba(4, 0), C_EMPTY);
      wr(A_MLO, 32'h0008);
      send(4, 1'b0, 32'h4);
      idle(1);
      check("R12 unmasked flag", 32'(irq), 32'h0);
      send(3, 1'b0, 32'h3);
      idle(1);
      check("R12 masked flag", 32'(irq), 32'h1);
      wr(A_FLO, 32'h0008);
      check("R12 after clear", 32'(irq), 32'h0);
      rd(A_FLO, v);      check("R9 w1c others kept", v, 32'h0010);

      // R5 BUSY, R6 stays FULL
      wr(mba(9, 0), C_EMPTY);
      send(9, 1'b0, 32'h900);
      cpu_rd = 1'b1; cpu_addr = mba(9, 0);
      @(negedge clk); cpu_rd = 1'b0;
      check("R5 busy", cpu_rdata, C_EMPTY | C_BUSY);
      rd(mba(9, 0), v);  check("R5 R6 full", v, C_FULL);
      rd(A_TMR, v);
      rd(mba(9, 0), v);  check("R6 stays full", v, C_FULL);

      // R2 held while locked, R3 release, R7 overrun on FULL
      clear_flags();
      send(9, 1'b0, 32'h999);
      idle(3);
      rd(mba(9, 1), v);  check("R2 id unchanged", v, 32'h900);
      rd(A_FLO, v);      check("R2 no flag", v, 32'h0);
      rd(A_TMR, v);
      idle(2);
      rd(mba(9, 1), v);  check("R3 id written", v, 32'h999);
      rd(A_FLO, v);      check("R3 flag", v, 32'h0200);
      rd(mba(9, 0), v);  check("R7 overrun", v, C_OVR);

      // R4 lock moves
      wr(mba(10, 0), C_EMPTY);
      wr(mba(11, 0), C_EMPTY);
      rd(mba(10, 0), v);
      send(10, 1'b0, 32'hA0A);
      rd(mba(11, 0), v);
      send(11, 1'b0, 32'hB0B);
      idle(3);
      rd(mba(10, 1), v); check("R4 old lock released", v, 32'hA0A);
      rd(mba(11, 1), v); check("R4 new lock holds", v, 32'h0);
      rd(A_TMR, v);
      idle(2);
      rd(mba(11, 1), v); check("R4 R3 held frame written", v, 32'hB0B);

      // R7 two frames for a locked mailbox
      wr(mba(12, 0), C_EMPTY);
      rd(mba(12, 0), v);
      send(12, 1'b0, 32'hC1);
      send(12, 1'b0, 32'hC2);
      rd(A_TMR, v);
      idle(2);
      rd(mba(12, 0), v); check("R7 replaced held frame", v, C_OVR);
      rd(mba(12, 1), v); check("R7 newest id", v, 32'hC2);

      // R8 status write on the arrival cycle
      clear_flags();
      wr(mba(13, 1), 32'h1313);
      wr(mba(13, 0), C_EMPTY);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_addr = mba(13, 0); cpu_wdata = C_EMPTY;
      rx_valid = 1'b1; rx_idx = 5'd13; rx_self = 1'b0; rx_id = 32'hDEAD;
      @(negedge clk); cpu_wr = 1'b0; rx_valid = 1'b0;
      idle(2);
      rd(A_FLO, v);      check("R8 same cycle flag", v, 32'h0);
      rd(mba(13, 1), v); check("R8 same cycle id", v, 32'h1313);
      // R8 status write while the frame is held
      rd(mba(13, 0), v);
      send(13, 1'b0, 32'hBEEF);
      wr(mba(13, 0), C_EMPTY);
      rd(A_TMR, v);
      idle(3);
      rd(A_FLO, v);      check("R8 held flag", v, 32'h0);
      rd(mba(13, 1), v); check("R8 held id", v, 32'h1313);
      rd(mba(13, 0), v); check("R8 held code", v, C_EMPTY);

      // R13 timer step and read latency
      @(negedge clk); cpu_rd = 1'b1; cpu_addr = A_TMR;
      @(negedge clk); t1 = cpu_rdata;
      @(negedge clk); t2 = cpu_rdata; cpu_rd = 1'b0;
      check("R13 timer step", (t2 - t1) & 32'hFFFF, 32'h1);
      idle(2);
      check("R13 rdata held", cpu_rdata, t2);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule